// File: doc/BRIEF.md
# JTAG Programming-Mode Instruction Controller

This block is the test-access side of a power-supply supervisor that keeps its configuration in nonvolatile memory. An IEEE 1149.1 TAP state machine, included in the block, walks the instruction and data scan paths. An 8-bit instruction register selects which data register sits between TDI and TDO. The choices are a 32-bit identification word, a snapshot of twelve voltage-comparator results, a configuration column address, a configuration data word (loaded from TDI, or captured from the selected column), the stored user signature, or a 1-bit bypass cell.

The block tracks a programming-mode flag. It issues single-cycle strobes that erase or program the configuration store, erase everything, or erase the user signature. It also raises a safe-state request, which tells the output stage to switch off its open-drain drivers and to hold FET-driver pins at their active-low level. Every nonvolatile action is gated by the programming-mode flag. An action fires only on the second rising TCK edge that the TAP spends in Run-Test-Idle, so passing through Run-Test-Idle briefly does nothing.

Top module: `jtag_prog_ctrl`

## Requirements
- R1: A strobe (erase_cfg 0x12, prog_cfg 0x13, erase_all 0x15, erase_sig 0x31) is high for exactly the one TCK cycle that follows the second rising edge spent in Run-Test-Idle. Staying longer gives no further pulse. Leaving Run-Test-Idle and coming back gives one new pulse.
- R2: While prog_mode is low, the erase and program instructions produce no strobe and leave the memory unchanged.
- R3: prog_mode rises at Update-IR of opcode 0x20. It falls at Update-IR of opcode 0x21, and whenever the TAP is in Test-Logic-Reset or rst is high.
- R4: safe_req goes high at Update-IR of 0x10, 0x11, 0x12, 0x13, 0x14, 0x15, 0x18, 0x20 or 0x31. It stays high until another opcode is loaded at Update-IR, and it is cleared by Test-Logic-Reset.
- R5: The instruction register captures 8'b00000001 at Capture-IR and shifts LSB first. Test-Logic-Reset makes IDCODE (0x01) the current instruction.
- R6: Under opcode 0x01 a 32-bit register captures IDCODE_VAL and shifts it out bit 0 first.
- R7: Under opcode 0x30, monitor_in is captured at Capture-DR. monitor_in[0] (monitor 1) is shifted out first, through monitor_in[11].
- R8: Under opcode 0x10, an ADDR_W-bit register is shifted and drives cfg_addr from Update-DR on. Under opcode 0x14, cfg_rd_data for that address is captured and shifted out LSB first.
- R9: Under opcode 0x11, a CFG_W-bit register is shifted and drives cfg_wr_data from Update-DR on.
- R10: Under opcode 0x32, sig_rd_data is captured at Capture-DR and shifted out LSB first.
- R11: Any undefined opcode selects a 1-bit bypass register that captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Scan data in |
| tdo | output | 1 | Scan data out |
| monitor_in | input | MON_N | Comparator results, bit 0 is monitor 1 |
| cfg_rd_data | input | CFG_W | Configuration column at cfg_addr |
| sig_rd_data | input | SIG_W | Stored user signature |
| prog_mode | output | 1 | Programming mode active |
| safe_req | output | 1 | Request to force outputs safe |
| cfg_addr | output | ADDR_W | Selected configuration column |
| cfg_wr_data | output | CFG_W | Data to program into the column |
| erase_cfg_stb | output | 1 | Erase configuration array |
| prog_cfg_stb | output | 1 | Program selected column |
| erase_all_stb | output | 1 | Erase all nonvolatile bits |
| erase_sig_stb | output | 1 | Erase user signature |

## Verification
The bench stays in Run-Test-Idle for several edges and records the edge on which each strobe appears. A design that fires on the first edge, or fires repeatedly, gives the wrong edge index or the wrong pulse count. It also leaves Run-Test-Idle and returns, to catch a counter that never rearms. Erase and program instructions are issued both before programming mode is enabled and after it is disabled; a missing gate shows up as a stray pulse or a corrupted memory word. Test-Logic-Reset is entered with programming mode and safe state both set, and the IDCODE is read back with no instruction shifted, which exposes a reset path that forgets any of the three. The bypass and status scans check capture values and bit order, which a reversed or off-by-one shift would garble.

// File: rtl/jpc_pkg.sv
package jpc_pkg;

  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    TS_TLR, TS_RTI, TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR,
    TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR, TS_SEL_IR, TS_CAP_IR,
    TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    DR_BYPASS, DR_IDCODE, DR_STATUS, DR_ADDR, DR_DATA_WR, DR_DATA_RD, DR_SIG
  } dr_sel_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_ERASE_CFG, ACT_PROG_CFG, ACT_ERASE_ALL, ACT_ERASE_SIG,
    ACT_PROG_EN, ACT_PROG_DIS
  } act_e;

  typedef struct packed {
    dr_sel_e dr;
    act_e    act;
    logic    safe;
  } instr_t;

  localparam logic [IR_W-1:0] OP_IDCODE    = 8'h01;
  localparam logic [IR_W-1:0] OP_ADDR_SET  = 8'h10;
  localparam logic [IR_W-1:0] OP_DATA_LOAD = 8'h11;
  localparam logic [IR_W-1:0] OP_ERASE_CFG = 8'h12;
  localparam logic [IR_W-1:0] OP_PROG_CFG  = 8'h13;
  localparam logic [IR_W-1:0] OP_READ_CFG  = 8'h14;
  localparam logic [IR_W-1:0] OP_ERASE_ALL = 8'h15;
  localparam logic [IR_W-1:0] OP_SAFE      = 8'h18;
  localparam logic [IR_W-1:0] OP_PROG_EN   = 8'h20;
  localparam logic [IR_W-1:0] OP_PROG_DIS  = 8'h21;
  localparam logic [IR_W-1:0] OP_STATUS    = 8'h30;
  localparam logic [IR_W-1:0] OP_ERASE_SIG = 8'h31;
  localparam logic [IR_W-1:0] OP_SIG_SHIFT = 8'h32;
  localparam logic [IR_W-1:0] IR_CAPTURE   = 8'b0000_0001;

  // R4 safe flag, R11 bypass for anything undefined
  function automatic instr_t decode_op(input logic [IR_W-1:0] op);
    instr_t r;
    r = '{dr: DR_BYPASS, act: ACT_NONE, safe: 1'b0};
    case (op)
      OP_IDCODE:    r.dr = DR_IDCODE;
      OP_STATUS:    r.dr = DR_STATUS;
      OP_SIG_SHIFT: r.dr = DR_SIG;
      OP_PROG_DIS:  r.act = ACT_PROG_DIS;
      OP_ADDR_SET:  r = '{dr: DR_ADDR,    act: ACT_NONE,      safe: 1'b1};
      OP_DATA_LOAD: r = '{dr: DR_DATA_WR, act: ACT_NONE,      safe: 1'b1};
      OP_READ_CFG:  r = '{dr: DR_DATA_RD, act: ACT_NONE,      safe: 1'b1};
      OP_ERASE_CFG: r = '{dr: DR_BYPASS,  act: ACT_ERASE_CFG, safe: 1'b1};
      OP_PROG_CFG:  r = '{dr: DR_BYPASS,  act: ACT_PROG_CFG,  safe: 1'b1};
      OP_ERASE_ALL: r = '{dr: DR_BYPASS,  act: ACT_ERASE_ALL, safe: 1'b1};
      OP_ERASE_SIG: r = '{dr: DR_BYPASS,  act: ACT_ERASE_SIG, safe: 1'b1};
      OP_PROG_EN:   r = '{dr: DR_BYPASS,  act: ACT_PROG_EN,   safe: 1'b1};
      OP_SAFE:      r.safe = 1'b1;
      default:      r = '{dr: DR_BYPASS, act: ACT_NONE, safe: 1'b0};
    endcase
    return r;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/jpc_tap.sv
module jpc_tap
  import jpc_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TS_TLR:      nxt = tms ? TS_TLR      : TS_RTI;
      TS_RTI:      nxt = tms ? TS_SEL_DR   : TS_RTI;
      TS_SEL_DR:   nxt = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: nxt = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: nxt = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: nxt = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   nxt = tms ? TS_SEL_DR   : TS_RTI;
      TS_SEL_IR:   nxt = tms ? TS_TLR      : TS_CAP_IR;
      TS_CAP_IR:   nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: nxt = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: nxt = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: nxt = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   nxt = tms ? TS_SEL_DR   : TS_RTI;
      default:     nxt = TS_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= TS_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/jpc_instr.sv
module jpc_instr
  import jpc_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_tdo,
  output instr_t     cur,
  output logic       prog_mode
);

  logic [IR_W-1:0] ir_sr;
  instr_t          nxt;

  assign nxt    = decode_op(ir_sr);
  assign ir_tdo = ir_sr[0];

  // R5 capture pattern and LSB-first shift
  always_ff @(posedge tck) begin
    if (rst)                        ir_sr <= '0;
    else if (state == TS_CAP_IR)    ir_sr <= IR_CAPTURE;
    else if (state == TS_SHIFT_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // R3 programming mode, R4 safe flag held in the decoded instruction, R5 reset to IDCODE
  always_ff @(posedge tck) begin
    if (rst || state == TS_TLR) begin
      cur       <= decode_op(OP_IDCODE);
      prog_mode <= 1'b0;
    end else if (state == TS_UPD_IR) begin
      cur <= nxt;
      if (nxt.act == ACT_PROG_EN)       prog_mode <= 1'b1;
      else if (nxt.act == ACT_PROG_DIS) prog_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/jpc_dregs.sv
module jpc_dregs
  import jpc_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          CFG_W      = 16,
  parameter int          SIG_W      = 32,
  parameter int          MON_N      = 12,
  parameter logic [31:0] IDCODE_VAL = 32'h0293_A043
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tdi,
  input  tap_state_e        state,
  input  dr_sel_e           sel,
  input  logic [MON_N-1:0]  monitor_in,
  input  logic [CFG_W-1:0]  cfg_rd_data,
  input  logic [SIG_W-1:0]  sig_rd_data,
  output logic              dr_tdo,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [CFG_W-1:0]  cfg_wr_data
);

  localparam int ID_W = 32;
  localparam int DR_W = imax(imax(ID_W, SIG_W), imax(imax(CFG_W, ADDR_W), MON_N));

  // one shared shift path; the selected register's length sets where TDI enters
  logic [DR_W-1:0] sr, cap_val, shf;
  int              len;

  always_comb begin
    unique case (sel)
      DR_IDCODE:  begin len = ID_W;   cap_val = DR_W'(IDCODE_VAL);  end // R6
      DR_STATUS:  begin len = MON_N;  cap_val = DR_W'(monitor_in);  end // R7
      DR_ADDR:    begin len = ADDR_W; cap_val = DR_W'(cfg_addr);    end // R8
      DR_DATA_WR: begin len = CFG_W;  cap_val = DR_W'(cfg_wr_data); end // R9
      DR_DATA_RD: begin len = CFG_W;  cap_val = DR_W'(cfg_rd_data); end // R8
      DR_SIG:     begin len = SIG_W;  cap_val = DR_W'(sig_rd_data); end // R10
      default:    begin len = 1;      cap_val = '0;                 end // R11
    endcase
  end

  always_comb begin
    shf = sr >> 1;
    for (int i = 0; i < DR_W; i++) begin
      if (i == len - 1)     shf[i] = tdi;
      else if (i >= len)    shf[i] = 1'b0;
    end
  end

  always_ff @(posedge tck) begin
    if (rst)                        sr <= '0;
    else if (state == TS_CAP_DR)    sr <= cap_val;
    else if (state == TS_SHIFT_DR)  sr <= shf;
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      cfg_addr    <= '0;
      cfg_wr_data <= '0;
    end else if (state == TS_UPD_DR) begin
      if (sel == DR_ADDR)    cfg_addr    <= sr[ADDR_W-1:0];
      if (sel == DR_DATA_WR) cfg_wr_data <= sr[CFG_W-1:0];
    end
  end

  assign dr_tdo = sr[0];

endmodule

// File: rtl/jtag_prog_ctrl.sv
module jtag_prog_ctrl
  import jpc_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          CFG_W      = 16,
  parameter int          SIG_W      = 32,
  parameter int          MON_N      = 12,
  parameter logic [31:0] IDCODE_VAL = 32'h0293_A043
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [MON_N-1:0]  monitor_in,
  input  logic [CFG_W-1:0]  cfg_rd_data,
  input  logic [SIG_W-1:0]  sig_rd_data,
  output logic              prog_mode,
  output logic              safe_req,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [CFG_W-1:0]  cfg_wr_data,
  output logic              erase_cfg_stb,
  output logic              prog_cfg_stb,
  output logic              erase_all_stb,
  output logic              erase_sig_stb
);

  localparam int NSTB = 4;

  tap_state_e      tap_state;
  instr_t          cur;
  logic            ir_tdo, dr_tdo;
  logic [1:0]      rti_cnt;
  logic            fire;
  logic [NSTB-1:0] stb_vec;

  jpc_tap u_tap (
    .tck(tck), .rst(rst), .tms(tms), .state(tap_state)
  );

  jpc_instr u_ir (
    .tck(tck), .rst(rst), .tdi(tdi), .state(tap_state),
    .ir_tdo(ir_tdo), .cur(cur), .prog_mode(prog_mode)
  );

  jpc_dregs #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SIG_W(SIG_W), .MON_N(MON_N),
    .IDCODE_VAL(IDCODE_VAL)
  ) u_dr (
    .tck(tck), .rst(rst), .tdi(tdi), .state(tap_state), .sel(cur.dr),
    .monitor_in(monitor_in), .cfg_rd_data(cfg_rd_data),
    .sig_rd_data(sig_rd_data), .dr_tdo(dr_tdo),
    .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data)
  );

  assign safe_req = cur.safe; // R4: a flop inside the instruction unit

  // R1 count edges in Run-Test-Idle, saturating so only the second edge fires
  always_ff @(posedge tck) begin
    if (rst)                       rti_cnt <= 2'd0;
    else if (tap_state != TS_RTI)  rti_cnt <= 2'd0;
    else if (rti_cnt != 2'd2)      rti_cnt <= rti_cnt + 2'd1;
  end

  assign fire = (tap_state == TS_RTI) && (rti_cnt == 2'd1) && prog_mode; // R2 gate

  always_ff @(posedge tck) begin
    if (rst) stb_vec <= '0;
    else begin
      stb_vec <= '0;
      if (fire) begin
        unique case (cur.act)
          ACT_ERASE_CFG: stb_vec[0] <= 1'b1;
          ACT_PROG_CFG:  stb_vec[1] <= 1'b1;
          ACT_ERASE_ALL: stb_vec[2] <= 1'b1;
          ACT_ERASE_SIG: stb_vec[3] <= 1'b1;
          default:       stb_vec    <= '0;
        endcase
      end
    end
  end

  assign erase_cfg_stb = stb_vec[0];
  assign prog_cfg_stb  = stb_vec[1];
  assign erase_all_stb = stb_vec[2];
  assign erase_sig_stb = stb_vec[3];

  always_comb begin
    if (tap_state == TS_SHIFT_IR)      tdo = ir_tdo;
    else if (tap_state == TS_SHIFT_DR) tdo = dr_tdo;
    else                               tdo = 1'b0;
  end

endmodule

// File: rtl/jpc_checker.sv
module jpc_checker
  import jpc_pkg::*;
(
  input logic       tck,
  input logic       rst,
  input tap_state_e state,
  input logic       prog_mode,
  input logic       safe_req,
  input logic [3:0] stb
);

  AST_STB_SECOND_RTI_EDGE: assert property (@(posedge tck) disable iff (rst)
    (|stb) |-> ($past(state) == TS_RTI && $past(state, 2) == TS_RTI)); // R1

  AST_STB_ONE_CYCLE: assert property (@(posedge tck) disable iff (rst)
    (|stb) |=> !(|stb)); // R1

  AST_STB_NEEDS_PROG: assert property (@(posedge tck) disable iff (rst)
    (|stb) |-> prog_mode); // R2

  AST_TLR_CLEARS: assert property (@(posedge tck) disable iff (rst)
    (state == TS_TLR) |=> (!prog_mode && !safe_req)); // R3

  AST_PROG_HOLD: assert property (@(posedge tck) disable iff (rst)
    (state != TS_UPD_IR && state != TS_TLR) |=> $stable(prog_mode)); // R3

  AST_SAFE_HOLD: assert property (@(posedge tck) disable iff (rst)
    (state != TS_UPD_IR && state != TS_TLR) |=> $stable(safe_req)); // R4

endmodule

bind jtag_prog_ctrl jpc_checker u_chk (
  .tck(tck), .rst(rst), .state(tap_state), .prog_mode(prog_mode),
  .safe_req(safe_req), .stb(stb_vec)
);

// File: tb/tb_jtag_prog_ctrl.sv
`timescale 1ns/1ps
module tb_jtag_prog_ctrl;

  localparam logic [31:0] IDV = 32'h0293_A043;
  localparam logic [7:0] C_IDCODE = 8'h01, C_ADDR = 8'h10, C_DATA = 8'h11,
    C_ERCFG = 8'h12, C_PROG = 8'h13, C_READ = 8'h14, C_ERALL = 8'h15,
    C_SAFE = 8'h18, C_PEN = 8'h20, C_PDIS = 8'h21, C_STAT = 8'h30,
    C_ERSIG = 8'h31, C_SIG = 8'h32, C_UNDEF = 8'h77;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo;
  logic [11:0] monitor_in = 12'h000;
  logic [15:0] cfg_rd_data;
  logic [31:0] sig_rd_data = 32'h0;
  logic prog_mode, safe_req, erase_cfg_stb, prog_cfg_stb, erase_all_stb, erase_sig_stb;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wr_data;
  logic [15:0] mem [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 tck = ~tck;

  jtag_prog_ctrl #(.IDCODE_VAL(IDV)) dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .monitor_in(monitor_in), .cfg_rd_data(cfg_rd_data), .sig_rd_data(sig_rd_data),
    .prog_mode(prog_mode), .safe_req(safe_req), .cfg_addr(cfg_addr),
    .cfg_wr_data(cfg_wr_data), .erase_cfg_stb(erase_cfg_stb),
    .prog_cfg_stb(prog_cfg_stb), .erase_all_stb(erase_all_stb),
    .erase_sig_stb(erase_sig_stb)
  );

  // nonvolatile store model
  always @(posedge tck) begin
    if (rst || erase_cfg_stb || erase_all_stb) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'hFFFF;
    end else if (prog_cfg_stb) mem[cfg_addr] <= cfg_wr_data;
  end
  assign cfg_rd_data = mem[cfg_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m; tdi = d;
    #1 o = tdo;
    @(posedge tck);
    #1;
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic shift_ir(input logic [7:0] op, output logic [7:0] cap);
    logic o;
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, op[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
  endtask

  task automatic shift_dr(input int w, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < w; i++) begin
      step(i == w - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
  endtask

  task automatic idle(input int n, input int which, output int first, output int cnt);
    logic o;
    logic [3:0] sv;
    first = 0; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      step(1'b0, 1'b0, o);
      sv = {erase_sig_stb, erase_all_stb, prog_cfg_stb, erase_cfg_stb};
      if (sv[which]) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic t_reset_state();
    chk("R3 reset prog_mode", {31'b0, prog_mode}, 0);
    chk("R4 reset safe_req", {31'b0, safe_req}, 0);
    chk("R1 reset strobes", {28'b0, erase_sig_stb, erase_all_stb, prog_cfg_stb, erase_cfg_stb}, 0);
  endtask

  task automatic t_idcode(input string tag);
    logic [31:0] d;
    shift_dr(32, 32'h0, d);
    chk(tag, d, IDV);
  endtask

  task automatic t_gate_off();
    logic [7:0] c; int f, n; logic [31:0] d;
    shift_ir(C_ERCFG, c);
    chk("R5 IR capture", {24'b0, c}, 32'h01);
    chk("R4 safe on erase opcode", {31'b0, safe_req}, 1);
    idle(4, 0, f, n);
    chk("R2 no erase without prog mode", n, 0);
    shift_ir(C_PROG, c);
    idle(4, 1, f, n);
    chk("R2 no program without prog mode", n, 0);
    shift_ir(C_READ, c);
    shift_dr(16, 32'h0, d);
    chk("R2 memory untouched", d, 32'h0000FFFF);
  endtask

  task automatic t_status();
    logic [7:0] c; logic [31:0] d;
    shift_ir(C_STAT, c);
    chk("R4 safe cleared by status", {31'b0, safe_req}, 0);
    monitor_in = 12'hA5C;
    shift_dr(12, 32'h0, d);
    chk("R7 status capture order", d, 32'h00000A5C);
    monitor_in = 12'h001;
    shift_dr(12, 32'h0, d);
    chk("R7 monitor 1 first", d, 32'h00000001);
  endtask

  task automatic t_program();
    logic [7:0] c; int f, n; logic [31:0] d;
    shift_ir(C_PEN, c);
    chk("R3 prog mode set", {31'b0, prog_mode}, 1);
    chk("R4 safe on enable", {31'b0, safe_req}, 1);
    shift_ir(C_ADDR, c);
    shift_dr(8, 32'h3C, d);
    chk("R8 address load", {24'b0, cfg_addr}, 32'h3C);
    shift_ir(C_DATA, c);
    shift_dr(16, 32'hBEEF, d);
    chk("R9 data load", {16'b0, cfg_wr_data}, 32'hBEEF);
    shift_ir(C_PROG, c);
    idle(5, 1, f, n);
    chk("R1 program strobe on second RTI edge", f, 2);
    chk("R1 single program pulse", n, 1);
    shift_dr(1, 32'h0, d);
    idle(3, 1, f, n);
    chk("R1 rearm after leaving RTI", n, 1);
    shift_ir(C_READ, c);
    shift_dr(16, 32'h0, d);
    chk("R8 read selected column", d, 32'hBEEF);
  endtask

  task automatic t_erases();
    logic [7:0] c; int f, n; logic [31:0] d;
    shift_ir(C_ERCFG, c);
    idle(3, 0, f, n);
    chk("R1 erase cfg pulse", n, 1);
    shift_ir(C_READ, c);
    shift_dr(16, 32'h0, d);
    chk("R1 erased column", d, 32'h0000FFFF);
    shift_ir(C_ERSIG, c);
    idle(4, 3, f, n);
    chk("R1 erase signature pulse", n, 1);
    shift_ir(C_ERALL, c);
    idle(4, 2, f, n);
    chk("R1 erase all on edge two", f, 2);
  endtask

  task automatic t_bypass_sig();
    logic [7:0] c; logic [31:0] d;
    shift_ir(C_UNDEF, c);
    chk("R4 undefined opcode clears safe", {31'b0, safe_req}, 0);
    shift_dr(2, 32'h3, d);
    chk("R11 bypass one bit", d, 32'h2);
    sig_rd_data = 32'h1234_5678;
    shift_ir(C_SIG, c);
    shift_dr(32, 32'h0, d);
    chk("R10 signature readout", d, 32'h1234_5678);
    shift_ir(C_SAFE, c);
    chk("R4 explicit safe opcode", {31'b0, safe_req}, 1);
    shift_ir(C_IDCODE, c);
    chk("R4 idcode clears safe", {31'b0, safe_req}, 0);
  endtask

  task automatic t_disable_tlr();
    logic [7:0] c; int f, n;
    shift_ir(C_PDIS, c);
    chk("R3 prog mode cleared", {31'b0, prog_mode}, 0);
    shift_ir(C_ERALL, c);
    idle(4, 2, f, n);
    chk("R2 no erase after disable", n, 0);
    shift_ir(C_PEN, c);
    chk("R3 prog mode again", {31'b0, prog_mode}, 1);
    tap_reset();
    chk("R3 TLR clears prog mode", {31'b0, prog_mode}, 0);
    chk("R4 TLR clears safe", {31'b0, safe_req}, 0);
    t_idcode("R5 TLR selects IDCODE");
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1 rst = 1'b0;
    t_reset_state();
    tap_reset();
    t_idcode("R6 IDCODE readout");
    t_gate_off();
    t_status();
    t_program();
    t_erases();
    t_bypass_sig();
    t_disable_tlr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule